// File: doc/BRIEF.md
# Six-Source Interrupt Request Controller

This block gathers interrupt requests from six sources and sends one request at a time to a CPU core. The sources are two external pins, three timer overflow sources and one serial source that is shared by two serial engines. An enable byte gates the sources. The byte holds one enable bit per source and a global enable bit. Pending flags are held inside the block and checked on each machine-phase tick. When at least one enabled source is pending, the block raises a request strobe with a vector index. The request stays up until the core acknowledges it.

After an acknowledge the controller counts as in service. It issues no new request until the core sends a return-from-interrupt pulse. Flags are cleared in two ways:
- The timer 0 flag, the timer 1 flag and the external flags in edge mode clear themselves when the core acknowledges them.
- The serial flag and both timer 2 flags are cleared only by a software clear write.

The timer 0 and timer 1 flags reach the poll one machine cycle after they are set. All other flags are polled at the next tick.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: The enable byte resets to 0 and reads back as written, except bit 6. Bit 6 is reserved: it always reads 0 and writes to it have no effect.
- R2: While enable bit 7 (global) is 0, no request is raised, whatever the other enable bits hold.
- R3: Enable bits 0 to 5 gate the sources with vector index 0 to 5. A pending source whose bit is 0 raises no request.
- R4: Among the enabled pending sources, the lowest index wins. The indices are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R5: A request rises only on a clock edge where the tick input is high. It then stays high, with its vector unchanged, until it is acknowledged.
- R6: A timer 0 or timer 1 overflow pulse is polled only at the second tick after the pulse. Any other source pulse is polled at the first tick after it.
- R7: The timer 2 request is the OR of an overflow flag and an external-event flag. An acknowledge clears neither flag. Software clear mask bit 5 clears the overflow flag and bit 6 clears the external-event flag.
- R8: An acknowledge clears the timer 0 flag, the timer 1 flag and an edge-mode external flag. The serial flag, set by either serial engine, stays set until software clear mask bit 4 is written.
- R9: From an acknowledge until a return-from-interrupt pulse, no new request is raised.
- R10: An external source in edge mode (mode bit 1) latches a high-to-low pin transition. In level mode (mode bit 0) it requests only while its pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_tick | input | 1 | One pulse per machine cycle; polling happens on this pulse |
| en_we | input | 1 | Write strobe for the enable byte |
| en_wdata | input | 8 | Enable byte write data |
| en_rdata | output | 8 | Enable byte read data |
| flag_clr_we | input | 1 | Software flag clear strobe |
| flag_clr_mask | input | 7 | Flags to clear; bits 0-4 follow the vector index, bit 5 is timer 2 overflow, bit 6 is timer 2 external event |
| ext_n | input | 2 | External interrupt pins, active low |
| ext_edge | input | 2 | Per-pin mode: 1 for edge, 0 for level |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| t2_ovf | input | 1 | Timer 2 overflow pulse |
| t2_ext | input | 1 | Timer 2 external-event pulse |
| spi_done | input | 1 | Serial peripheral event pulse |
| uart_done | input | 1 | UART event pulse |
| irq_req | output | 1 | Request strobe to the core |
| irq_vec | output | 3 | Vector index of the request |
| irq_ack | input | 1 | Core acknowledge |
| irq_reti | input | 1 | Return-from-interrupt pulse |

## Verification
The hardest case to reach from the ports is a set of pending flags that the poll sees all at once. A timer 0 or timer 1 flag becomes visible one tick later than the others, so a source of lower priority could otherwise win a poll before them. The stimulus first writes the enable byte to zero. It then raises a random set of sources and gives one tick so that the delayed flags settle. Only after that does it write a random enable byte and issue the poll that is checked against the priority order. Directed sequences then cover the service window and the flags that survive an acknowledge, using acknowledge and return pulses interleaved with ticks.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 6;
  localparam int VW      = $clog2(NSRC);
  localparam int EN_W    = 8;
  localparam int GIE_BIT = 7;
  localparam int RSV_BIT = 6;
  localparam int CLR_W   = NSRC + 1;
  localparam int NPAIR   = 2;

  typedef enum logic [VW-1:0] {
    V_EXT0 = 3'd0,
    V_TMR0 = 3'd1,
    V_EXT1 = 3'd2,
    V_TMR1 = 3'd3,
    V_SER  = 3'd4,
    V_TMR2 = 3'd5
  } vec_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [EN_W-1:0] wdata,
  output logic [EN_W-1:0] q
);
  localparam logic [EN_W-1:0] KEEP = ~(EN_W'(1) << RSV_BIT);

  logic [EN_W-1:0] q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (wr) q_d = wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (wr) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NPAIR-1:0] ext_n,
  input  logic [NPAIR-1:0] ext_edge,
  input  logic [NPAIR-1:0] tmr_ovf,
  input  logic             t2_ovf,
  input  logic             t2_ext,
  input  logic             ser_set,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_mask,
  input  logic [NSRC-1:0]  ack_clr,
  output logic [NSRC-1:0]  vis
);
  logic [CLR_W-1:0] clr;
  assign clr = clr_we ? clr_mask : '0;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    localparam int EI = 2 * i;
    localparam int TI = 2 * i + 1;
    logic s1_q, s2_q, ef_q, ef_d, fall;
    logic tf_q, tf_d, tl_q, tl_d, tclr;

    assign fall = s2_q & ~s1_q;
    assign tclr = clr[TI] | ack_clr[TI];

    always_comb begin
      ef_d = ef_q;
      if (!ext_edge[i]) ef_d = 1'b0;
      else begin
        if (clr[EI] || ack_clr[EI]) ef_d = 1'b0;
        if (fall) ef_d = 1'b1;
      end
      tf_d = tf_q;
      if (tclr) tf_d = 1'b0;
      if (tmr_ovf[i]) tf_d = 1'b1;
      tl_d = tl_q;
      if (tick) tl_d = tf_q;
      if (tclr) tl_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        ef_q <= 1'b0;
        tf_q <= 1'b0;
        tl_q <= 1'b0;
      end else begin
        s1_q <= ext_n[i];
        s2_q <= s1_q;
        ef_q <= ef_d;
        tf_q <= tf_d;
        tl_q <= tl_d;
      end
    end

    assign vis[EI] = ext_edge[i] ? ef_q : ~s1_q;
    assign vis[TI] = tl_q;
  end

  logic sf_q, sf_d, t2o_q, t2o_d, t2x_q, t2x_d;

  always_comb begin
    sf_d = sf_q;
    if (clr[V_SER]) sf_d = 1'b0;
    if (ser_set) sf_d = 1'b1;
    t2o_d = t2o_q;
    if (clr[V_TMR2]) t2o_d = 1'b0;
    if (t2_ovf) t2o_d = 1'b1;
    t2x_d = t2x_q;
    if (clr[NSRC]) t2x_d = 1'b0;
    if (t2_ext) t2x_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q  <= 1'b0;
      t2o_q <= 1'b0;
      t2x_q <= 1'b0;
    end else begin
      sf_q  <= sf_d;
      t2o_q <= t2o_d;
      t2x_q <= t2x_d;
    end
  end

  assign vis[V_SER]  = sf_q;
  assign vis[V_TMR2] = t2o_q | t2x_q;
endmodule

// File: rtl/irq_poll.sv
module irq_poll
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NSRC-1:0] vis,
  input  logic [EN_W-1:0] en,
  input  logic            ack,
  input  logic            reti,
  output logic            req,
  output logic [VW-1:0]   vec,
  output logic            svc,
  output logic [NSRC-1:0] ack_clr
);
  logic [NSRC-1:0] elig;
  logic [VW-1:0]   win;
  logic            take;
  logic            req_q, req_d, svc_q, svc_d;
  logic [VW-1:0]   vec_q, vec_d;

  assign elig = en[GIE_BIT] ? (vis & en[NSRC-1:0]) : '0;
  assign take = req_q & ack;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) win = VW'(i);
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      ack_clr[i] = take && (vec_q == VW'(i));
  end

  always_comb begin
    req_d = req_q;
    vec_d = vec_q;
    svc_d = svc_q;
    if (take) begin
      req_d = 1'b0;
      svc_d = 1'b1;
    end else if (reti && svc_q) begin
      svc_d = 1'b0;
    end else if (tick && !req_q && !svc_q && (|elig)) begin
      req_d = 1'b1;
      vec_d = win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
      svc_q <= 1'b0;
    end else begin
      req_q <= req_d;
      vec_q <= vec_d;
      svc_q <= svc_d;
    end
  end

  assign req = req_q;
  assign vec = vec_q;
  assign svc = svc_q;
endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_tick,
  input  logic             en_we,
  input  logic [EN_W-1:0]  en_wdata,
  output logic [EN_W-1:0]  en_rdata,
  input  logic             flag_clr_we,
  input  logic [CLR_W-1:0] flag_clr_mask,
  input  logic [NPAIR-1:0] ext_n,
  input  logic [NPAIR-1:0] ext_edge,
  input  logic             t0_ovf,
  input  logic             t1_ovf,
  input  logic             t2_ovf,
  input  logic             t2_ext,
  input  logic             spi_done,
  input  logic             uart_done,
  output logic             irq_req,
  output logic [VW-1:0]    irq_vec,
  input  logic             irq_ack,
  input  logic             irq_reti
);
  logic [EN_W-1:0] en_q;
  logic [NSRC-1:0] vis;
  logic [NSRC-1:0] ack_clr;
  logic            in_svc;

  irq_enable_reg u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (en_we),
    .wdata (en_wdata),
    .q     (en_q)
  );

  irq_src_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (phase_tick),
    .ext_n    (ext_n),
    .ext_edge (ext_edge),
    .tmr_ovf  ({t1_ovf, t0_ovf}),
    .t2_ovf   (t2_ovf),
    .t2_ext   (t2_ext),
    .ser_set  (spi_done | uart_done),
    .clr_we   (flag_clr_we),
    .clr_mask (flag_clr_mask),
    .ack_clr  (ack_clr),
    .vis      (vis)
  );

  irq_poll u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (phase_tick),
    .vis     (vis),
    .en      (en_q),
    .ack     (irq_ack),
    .reti    (irq_reti),
    .req     (irq_req),
    .vec     (irq_vec),
    .svc     (in_svc),
    .ack_clr (ack_clr)
  );

  assign en_rdata = en_q;
endmodule

// File: rtl/mcu_irq_ctrl_chk.sv
module mcu_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phase_tick,
  input logic [7:0] en_rdata,
  input logic       irq_req,
  input logic [2:0] irq_vec,
  input logic       irq_ack,
  input logic       in_svc
);
  AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    en_rdata[6] == 1'b0); // R1
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(en_rdata[7])); // R2
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec <= 3'd5); // R4
  AST_REQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(phase_tick)); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec)); // R5
  AST_ACK_ENTERS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack |=> !irq_req && in_svc); // R9
  AST_NO_REQ_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> !$past(in_svc)); // R9
endmodule

bind mcu_irq_ctrl mcu_irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase_tick (phase_tick),
  .en_rdata   (en_rdata),
  .irq_req    (irq_req),
  .irq_vec    (irq_vec),
  .irq_ack    (irq_ack),
  .in_svc     (in_svc)
);

// File: tb/mcu_irq_ctrl_test.sv
module mcu_irq_ctrl_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_tick = 1'b0;
  logic       en_we = 1'b0;
  logic [7:0] en_wdata = '0;
  logic [7:0] en_rdata;
  logic       flag_clr_we = 1'b0;
  logic [6:0] flag_clr_mask = '0;
  logic [1:0] ext_n = 2'b11;
  logic [1:0] ext_edge = 2'b11;
  logic       t0_ovf = 1'b0, t1_ovf = 1'b0, t2_ovf = 1'b0, t2_ext = 1'b0;
  logic       spi_done = 1'b0, uart_done = 1'b0;
  logic       irq_req;
  logic [2:0] irq_vec;
  logic       irq_ack = 1'b0, irq_reti = 1'b0;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mcu_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick),
    .en_we(en_we), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
    .ext_n(ext_n), .ext_edge(ext_edge),
    .t0_ovf(t0_ovf), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf), .t2_ext(t2_ext),
    .spi_done(spi_done), .uart_done(uart_done),
    .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_reti(irq_reti)
  );

  function automatic int seen();
    return irq_req ? int'(irq_vec) : -1;
  endfunction

  function automatic int exp_vec(logic [5:0] pend, logic [7:0] en);
    if (!en[7]) return -1;
    for (int i = 0; i < 6; i++)
      if (pend[i] && en[i]) return i;
    return -1;
  endfunction

  task automatic check(string rq, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) phase_tick = 1'b1;
    @(negedge clk) phase_tick = 1'b0;
  endtask

  task automatic wr_en(logic [7:0] v);
    @(negedge clk) begin en_we = 1'b1; en_wdata = v; end
    @(negedge clk) en_we = 1'b0;
  endtask

  task automatic clr(logic [6:0] m);
    @(negedge clk) begin flag_clr_we = 1'b1; flag_clr_mask = m; end
    @(negedge clk) flag_clr_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
  endtask

  task automatic reti();
    @(negedge clk) irq_reti = 1'b1;
    @(negedge clk) irq_reti = 1'b0;
  endtask

  task automatic pulse(int src);
    @(negedge clk);
    case (src)
      1: t0_ovf = 1'b1;
      3: t1_ovf = 1'b1;
      4: spi_done = 1'b1;
      5: uart_done = 1'b1;
      6: t2_ovf = 1'b1;
      7: t2_ext = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    {t0_ovf, t1_ovf, spi_done, uart_done, t2_ovf, t2_ext} = '0;
  endtask

  task automatic ext_fall(int p);
    ext_n[p] = 1'b0;
    idle(3);
    ext_n[p] = 1'b1;
    idle(3);
  endtask

  task automatic clean();
    wr_en(8'h00);
    if (irq_req) ack();
    reti();
    ext_n = 2'b11;
    idle(3);
    clr(7'h7F);
    ext_edge = 2'b11;
    idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    check("R1 reset enable", int'(en_rdata), 0);
    check("R5 reset req", int'(irq_req), 0);

    wr_en(8'hFF);
    check("R1 reserved bit", int'(en_rdata), 8'hBF);
    wr_en(8'h00);

    // R6 and R8: timer 0 lag, auto clear
    wr_en(8'h82);
    pulse(1);
    tick();
    check("R6 timer0 not yet", seen(), -1);
    tick();
    check("R6 timer0 next cycle", seen(), 1);
    ack();
    reti();
    tick(); tick();
    check("R8 timer0 cleared by ack", seen(), -1);
    clean();

    // R6, R5, R9, R7: timer 2
    wr_en(8'hA0);
    pulse(6);
    tick();
    check("R6 timer2 same cycle", seen(), 5);
    tick(); idle(2); tick();
    check("R5 request held", seen(), 5);
    ack();
    check("R9 ack drops request", seen(), -1);
    tick(); tick();
    check("R9 no request in service", seen(), -1);
    reti();
    tick();
    check("R7 timer2 kept after ack", seen(), 5);
    ack(); reti();
    clr(7'h20);
    tick();
    check("R7 overflow flag cleared", seen(), -1);
    pulse(7);
    tick();
    check("R7 external flag requests", seen(), 5);
    ack(); reti();
    clr(7'h40);
    tick();
    check("R7 external flag cleared", seen(), -1);
    clean();

    // R8 serial persists
    wr_en(8'h90);
    pulse(5);
    tick();
    check("R8 serial from uart", seen(), 4);
    ack(); reti();
    tick();
    check("R8 serial kept after ack", seen(), 4);
    ack(); reti();
    clr(7'h10);
    tick();
    check("R8 serial software clear", seen(), -1);
    clean();

    // R10 level mode
    ext_edge = 2'b00;
    wr_en(8'h81);
    ext_n[0] = 1'b0;
    idle(3);
    tick();
    check("R10 level request", seen(), 0);
    ack(); reti();
    tick();
    check("R10 level persists", seen(), 0);
    ack();
    ext_n[0] = 1'b1;
    idle(3);
    reti();
    tick();
    check("R10 level released", seen(), -1);
    clean();

    // R10 and R8 edge mode
    wr_en(8'h84);
    ext_fall(1);
    tick();
    check("R10 edge latched", seen(), 2);
    ack(); reti();
    tick();
    check("R8 edge flag cleared by ack", seen(), -1);
    clean();

    // R2 and R3
    wr_en(8'h3F);
    pulse(6);
    tick(); tick();
    check("R2 global off", seen(), -1);
    wr_en(8'h80);
    tick();
    check("R3 source disabled", seen(), -1);
    wr_en(8'hA0);
    tick();
    check("R3 source enabled", seen(), 5);
    clean();

    // R4 random priority
    for (int t = 0; t < 60; t++) begin
      logic [5:0] pend;
      logic [7:0] en;
      pend = 6'($urandom);
      en = 8'($urandom) | 8'h80;
      if (t % 7 == 3) en[7] = 1'b0;
      if (pend[0]) ext_fall(0);
      if (pend[2]) ext_fall(1);
      if (pend[1]) pulse(1);
      if (pend[3]) pulse(3);
      if (pend[4]) pulse(($urandom % 2) ? 4 : 5);
      if (pend[5]) pulse(($urandom % 2) ? 6 : 7);
      tick();
      wr_en(en);
      tick();
      check("R4 priority", seen(), exp_vec(pend, en & 8'hBF));
      clean();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule